// File: doc/BRIEF.md
# Serial Byte Receiver with Start Validation and Hunt Timeout

This block receives one asynchronous serial character at a time: a low start bit, eight data bits sent least significant first, and a high stop bit, with no parity. The line is idle high. The bit period is a parameter given in system clock cycles, and the default suits a 9600 bit/s line once it is scaled to the real clock. Before any decision is made, the serial input passes through a two-stage synchronizer.

A controller arms the receiver with a one-cycle request. The receiver then hunts for a start bit for a bounded number of clock cycles. When it first sees the line low, it waits half a bit period and samples the line again. If the line has gone high, the low level was a glitch, so the receiver drops it and goes on hunting. If the line is still low, the start bit is accepted. Each data bit is then sampled one full bit period after the previous sample, and the stop bit one bit period after the last data bit.

The outcome is reported by a single-cycle completion pulse. Two flags and the byte are registered together with that pulse and hold their values until the next completion. After the pulse the receiver is idle and ignores the line until it is armed again. The result interface carries no ready signal and cannot apply back-pressure: a consumer must capture the byte in the cycle the pulse is high. A request to arm while a reception is in progress is dropped.

Top module: `uart_rx_hunt`

## Requirements
- R1: While reset is asserted and afterwards until the first completion, done_o, ok_o and tmo_o are 0 and byte_o is 8'h00.
- R2: After arming, a frame made of start bit 0, data bits b[0] first through b[7], and stop bit 1, each bit lasting BIT_CYC clock cycles, produces exactly one done_o pulse with byte_o = b, ok_o = 1 and tmo_o = 0.
- R3: A low level shorter than half a bit period during hunting produces no completion. Hunting resumes, and a valid frame that follows is received correctly.
- R4: A frame whose stop bit is 0 completes with ok_o = 0 and tmo_o = 0, and byte_o still carries the eight sampled data bits.
- R5: If the line stays high for TIMEOUT_CYC hunting cycles after arming, done_o pulses with ok_o = 0 and tmo_o = 1, and byte_o keeps its previous value. With the arm request sampled at clock edge 0, this pulse is high after edge TIMEOUT_CYC. Cycles spent checking a rejected start edge do not count toward the timeout.
- R6: done_o is never high for two consecutive cycles. ok_o, tmo_o and byte_o change only in a cycle in which done_o is high.
- R7: After a completion, no further done_o pulse occurs until arm_i is asserted again, even if a complete frame arrives on the line.
- R8: An arm_i pulse during a reception has no effect: the reception finishes with the same byte and flags and a single done_o pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle request to start hunting; honoured only when idle |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | 1 when the last completion was a frame with a high stop bit |
| tmo_o | output | 1 | 1 when the last completion was a hunt timeout |
| byte_o | output | DATA_BITS | Last received data byte, LSB received first |

## Verification
If the bit index or the bit timer is corrupted, the byte is sampled at the wrong bit centres. This shows up as a wrong byte_o, or as a completion pulse that comes a whole bit early or late, within one frame time of the fault. If the hunt timer is corrupted, the timeout pulse lands away from edge TIMEOUT_CYC, or never comes, which the watchdog catches. If the idle or busy decoding is wrong, there are extra or missing done_o pulses when a frame arrives without arming, or when arm_i is pulsed during a reception. The glitch cases show whether the mid-start recheck really resumes hunting rather than treating the glitch as a start bit.

// File: rtl/uart_rx_hunt_pkg.sv
package uart_rx_hunt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CHECK,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= RST_VAL;
    else        stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_down_ctr.sv
module rx_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (ld_i)                   cnt_q <= ld_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rx_shreg.sv
module rx_shreg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [N-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_o <= '0;
    else if (shift_i) data_o <= {bit_i, data_o[N-1:1]};
  end
endmodule

// File: rtl/uart_rx_hunt.sv
module uart_rx_hunt
  import uart_rx_hunt_pkg::*;
#(
  parameter int BIT_CYC     = 16,
  parameter int TIMEOUT_CYC = 800,
  parameter int DATA_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_i,
  input  logic                 rxd_i,
  output logic                 done_o,
  output logic                 ok_o,
  output logic                 tmo_o,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int HALF_CYC = BIT_CYC / 2;
  localparam int BW = $clog2(BIT_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int IW = $clog2(DATA_BITS + 1);
  localparam logic [BW-1:0] BIT_LD  = BW'(BIT_CYC - 1);
  localparam logic [BW-1:0] HALF_LD = BW'(HALF_CYC - 1);
  localparam logic [TW-1:0] TMO_LD  = TW'(TIMEOUT_CYC - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

  logic line;
  rx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(line)
  );

  rx_state_e state_q, state_d;

  logic          bt_ld, bt_zero;
  logic [BW-1:0] bt_val;
  rx_down_ctr #(.W(BW)) u_bit_tmr (
    .clk(clk), .rst_n(rst_n), .ld_i(bt_ld), .ld_val_i(bt_val),
    .dec_i(1'b1), .zero_o(bt_zero)
  );

  logic to_ld, to_dec, to_zero;
  rx_down_ctr #(.W(TW)) u_hunt_tmr (
    .clk(clk), .rst_n(rst_n), .ld_i(to_ld), .ld_val_i(TMO_LD),
    .dec_i(to_dec), .zero_o(to_zero)
  );

  logic                 sh_en;
  logic [DATA_BITS-1:0] sh_data;
  rx_shreg #(.N(DATA_BITS)) u_shreg (
    .clk(clk), .rst_n(rst_n), .shift_i(sh_en), .bit_i(line), .data_o(sh_data)
  );

  logic [IW-1:0] idx_q;
  logic          idx_clr, idx_inc;
  logic          fin, fin_ok, fin_tmo;

  always_comb begin
    state_d = state_q;
    bt_ld   = 1'b0;
    bt_val  = BIT_LD;
    to_ld   = 1'b0;
    to_dec  = 1'b0;
    sh_en   = 1'b0;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    fin     = 1'b0;
    fin_ok  = 1'b0;
    fin_tmo = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (arm_i) begin
          state_d = ST_HUNT;
          to_ld   = 1'b1;
        end
      end
      ST_HUNT: begin
        if (to_zero) begin
          fin     = 1'b1;
          fin_tmo = 1'b1;
          state_d = ST_IDLE;
        end else begin
          to_dec = 1'b1;
          if (!line) begin
            state_d = ST_CHECK;
            bt_ld   = 1'b1;
            bt_val  = HALF_LD;
          end
        end
      end
      ST_CHECK: begin
        if (bt_zero) begin
          if (line) begin
            state_d = ST_HUNT;
          end else begin
            state_d = ST_DATA;
            bt_ld   = 1'b1;
            idx_clr = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bt_zero) begin
          sh_en   = 1'b1;
          idx_inc = 1'b1;
          bt_ld   = 1'b1;
          if (idx_q == LAST_IDX) state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (bt_zero) begin
          fin     = 1'b1;
          fin_ok  = line;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_clr)      idx_q <= '0;
      else if (idx_inc) idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      tmo_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        ok_o  <= fin_ok;
        tmo_o <= fin_tmo;
        if (!fin_tmo) byte_o <= sh_data;
      end
    end
  end
endmodule

// File: rtl/uart_rx_hunt_chk.sv
module uart_rx_hunt_chk
  import uart_rx_hunt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 800,
  parameter int DATA_BITS   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 arm_i,
  input logic                 done_o,
  input logic                 ok_o,
  input logic                 tmo_o,
  input logic [DATA_BITS-1:0] byte_o,
  input rx_state_e            st
);
  logic [31:0] since_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_arm <= '0;
    else if (st == ST_IDLE && arm_i) since_arm <= '0;
    else if (since_arm != '1)        since_arm <= since_arm + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(byte_o) && $stable(ok_o) && $stable(tmo_o))); // R6
  AST_TMO_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && tmo_o) |-> !ok_o); // R5
  AST_TMO_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && tmo_o) |-> (since_arm >= 32'(TIMEOUT_CYC))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> !done_o); // R7
endmodule

bind uart_rx_hunt uart_rx_hunt_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC), .DATA_BITS(DATA_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .done_o(done_o), .ok_o(ok_o),
  .tmo_o(tmo_o), .byte_o(byte_o), .st(state_q)
);

// File: tb/test_uart_rx_hunt.sv
module test_uart_rx_hunt;
  localparam int BIT = 16;
  localparam int TMO = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0;
  logic rxd_i = 1'b1;
  logic done_o, ok_o, tmo_o;
  logic [7:0] byte_o;

  int total = 0;
  int bad = 0;
  int ndone = 0;
  int pulse_err = 0;
  logic prev_done = 1'b0;
  logic cap_ok, cap_tmo;
  logic [7:0] cap_byte;

  always #2 clk = ~clk;

  uart_rx_hunt #(.BIT_CYC(BIT), .TIMEOUT_CYC(TMO), .DATA_BITS(8)) i_uart_rx_hunt (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .rxd_i(rxd_i),
    .done_o(done_o), .ok_o(ok_o), .tmo_o(tmo_o), .byte_o(byte_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        ndone++;
        cap_ok = ok_o;
        cap_tmo = tmo_o;
        cap_byte = byte_o;
        if (prev_done) pulse_err++;
      end
      prev_done = done_o;
    end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic frame_bit(input logic [7:0] b, input logic stop, input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return stop;
    return b[i-1];
  endfunction

  task automatic arm_pulse();
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input bit arm_mid);
    for (int i = 0; i < 10; i++) begin
      rxd_i = frame_bit(b, stop, i);
      for (int c = 0; c < BIT; c++) begin
        arm_i = (arm_mid && i == 5 && c == 0);
        @(negedge clk);
      end
    end
    arm_i = 1'b0;
    rxd_i = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic recv(input logic [7:0] b, input logic stop, input bit arm_mid, input string req);
    int start;
    start = ndone;
    arm_pulse();
    repeat (4) @(negedge clk);
    send_frame(b, stop, arm_mid);
    chk(ndone == start + 1, req, "done count", ndone - start, 1);
    chk(cap_byte == b, req, "byte", cap_byte, b);
    chk(cap_ok == stop, req, "ok", cap_ok, stop);
    chk(cap_tmo == 1'b0, req, "tmo", cap_tmo, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int cyc;
    int start;
    logic [7:0] b;
    logic stop;
    bit am;
    seed = $urandom(32'd4711);

    repeat (3) @(negedge clk);
    chk({done_o, ok_o, tmo_o, byte_o} == 11'd0, "R1", "outputs in reset",
        {done_o, ok_o, tmo_o, byte_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({done_o, ok_o, tmo_o, byte_o} == 11'd0, "R1", "outputs after reset",
        {done_o, ok_o, tmo_o, byte_o}, 0);

    // R2 directed patterns
    recv(8'hA5, 1'b1, 1'b0, "R2");
    recv(8'h00, 1'b1, 1'b0, "R2");
    recv(8'hFF, 1'b1, 1'b0, "R2");
    recv(8'h01, 1'b1, 1'b0, "R2");
    recv(8'h80, 1'b1, 1'b0, "R2");

    // R6 hold after completion
    repeat (30) @(negedge clk);
    chk(byte_o == cap_byte && ok_o == cap_ok, "R6", "held result", byte_o, cap_byte);

    // R4 stop bit low
    recv(8'h3C, 1'b0, 1'b0, "R4");

    // R8 arm during reception
    recv(8'h5A, 1'b1, 1'b1, "R8");

    // R7 frame without arm
    start = ndone;
    send_frame(8'h77, 1'b1, 1'b0);
    repeat (BIT) @(negedge clk);
    chk(ndone == start, "R7", "done without arm", ndone - start, 0);

    // R3 glitch then valid frame
    start = ndone;
    arm_pulse();
    repeat (4) @(negedge clk);
    rxd_i = 1'b0;
    repeat (3) @(negedge clk);
    rxd_i = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk(ndone == start, "R3", "done after glitch", ndone - start, 0);
    send_frame(8'hC3, 1'b1, 1'b0);
    chk(ndone == start + 1, "R3", "done count", ndone - start, 1);
    chk(cap_byte == 8'hC3 && cap_ok, "R3", "byte after glitch", cap_byte, 8'hC3);

    // R5 exact timeout
    b = byte_o;
    start = ndone;
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < TMO + 50) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == TMO + 1, "R5", "timeout cycle", cyc, TMO + 1);
    chk(tmo_o == 1'b1 && ok_o == 1'b0, "R5", "tmo/ok", {tmo_o, ok_o}, 2);
    chk(byte_o == b, "R5", "byte kept", byte_o, b);
    @(negedge clk);
    chk(ndone == start + 1, "R5", "one timeout pulse", ndone - start, 1);

    // R5 with a glitch inside the hunt window
    start = ndone;
    arm_pulse();
    repeat (100) @(negedge clk);
    rxd_i = 1'b0;
    repeat (2) @(negedge clk);
    rxd_i = 1'b1;
    repeat (TMO + BIT) @(negedge clk);
    chk(ndone == start + 1 && cap_tmo, "R5", "timeout after glitch", ndone - start, 1);

    // Random frames
    for (int n = 0; n < 24; n++) begin
      b = 8'($urandom);
      stop = (($urandom % 5) != 0);
      am = (($urandom % 4) == 0);
      recv(b, stop, am, stop ? "R2" : "R4");
    end

    chk(pulse_err == 0, "R6", "multi-cycle done", pulse_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule